// File: doc/BRIEF.md
# UART Register Front End

This block is the software-facing half of a memory-mapped serial port. A processor reaches it through a 32-bit register port inside a 1 KiB window. It holds the control, status, interrupt and configuration registers. Received bytes arrive on a byte-wide valid/ready stream and collect in an 8-entry receive FIFO. Software drains the FIFO through a data register and can inspect the oldest byte through a non-destructive peek register. Each write to the data register sends its low byte out on a transmit stream. That stream is treated as always drained, so it has no back-pressure.

A single interrupt line combines the stored interrupt flags with their enables. Two flags are produced. The receive-threshold flag is set when a push leaves the FIFO at or above a programmable level. The transmit-half-empty flag is set by every transmit write. Software clears flags by writing ones. Serial bit timing, baud generation, flow control, DMA and wake-up logic are outside this block. Their configuration registers are plain storage here.

Register words sit at 4-byte steps from offset 0x00, in this order: control, status, interrupt enable, interrupt flags, clock divider, oversampling, peek, pin control, FIFO data, DMA, wake enable, wake flags.

Top module: `uart_reg_front`

## Requirements
- R1: `rx_ready` is high only while control bit 15 (baud clock enable) is set and the FIFO holds fewer than 8 bytes. A byte presented while `rx_ready` is low is not stored.
- R2: Reading the FIFO data word (offset 0x20) returns the oldest byte and removes it. When the FIFO is empty the read returns 0. Reading the peek word (offset 0x18) returns the oldest byte without removing it, and returns 0 when the FIFO is empty.
- R3: When a byte is pushed and the resulting occupancy is at least control bits [3:0], flag bit 4 is set at the same clock edge. A threshold of 0 sets the flag on any push. A threshold above 8 never sets it.
- R4: `irq` is high exactly when some bit is set in both the flag word (offset 0x0C) and the enable word (offset 0x08).
- R5: A write to the flag word clears every flag bit written as one and leaves the other bits unchanged. A flag-setting event in the same cycle wins over the clear.
- R6: A write to the FIFO data word raises `tx_valid` for exactly one cycle, starting at the clock edge that takes the write. `tx_data` carries bits [7:0] of the written value, and flag bit 6 is set at the same edge.
- R7: A control write with bit 6 set empties the FIFO. Bits 5 and 6 are never stored. When bit 15 is written as one, bit 19 is stored as one.
- R8: The status word (offset 0x04) is read-only. It shows the FIFO level in bits [11:8], receive-empty in bit 4 and transmit-empty in bit 6, and transmit-empty always reads 1.
- R9: After reset, status reads 0x50, the pin-control word reads 0x2 (bit 1 is the request-to-send bit), every other register reads 0, `irq` is low and the FIFO is empty.
- R10: A read at an unmapped word or at a byte address not aligned to 4 returns 0. A write there changes nothing.
- R11: A push and a popping read in the same cycle both take place, and the FIFO level is unchanged.
- R12: The clock divider (0x10), oversampling (0x14), pin control (0x1C), DMA (0x24), wake enable (0x28) and wake flag (0x2C) words read back the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte address inside the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid combinationally during a read cycle |
| rx_valid | input | 1 | Received byte offered |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Byte accepted when high with `rx_valid` |
| tx_valid | output | 1 | One-cycle transmit strobe |
| tx_data | output | 8 | Transmitted byte |
| irq | output | 1 | Interrupt request |

## Verification
Read data is combinational, so it is sampled during the read cycle itself, before the edge at which a pop or a write takes effect. Pushes, flag sets and clears, flushes and register writes all land at the edge that ends their cycle. The bench therefore reads status, flags or `irq` only in a later cycle. `tx_valid` is registered, so it is checked one time step after the write edge, and its return to low is checked after the following edge. The threshold rule is swept over every threshold from 0 to 9 and every occupancy from 1 to 8, and the expected flag is computed as a comparison in the bench.

// File: rtl/uart_fe_pkg.sv
// Package: shared register map and bit positions of the UART front end.
// Assumes: word-aligned 32-bit accesses; word index = byte address >> 2.
package uart_fe_pkg;
    // Word indices of the register map
    localparam logic [7:0] W_CTRL   = 8'd0;
    localparam logic [7:0] W_STAT   = 8'd1;
    localparam logic [7:0] W_INTEN  = 8'd2;
    localparam logic [7:0] W_FLAG   = 8'd3;
    localparam logic [7:0] W_CLKDIV = 8'd4;
    localparam logic [7:0] W_OSR    = 8'd5;
    localparam logic [7:0] W_PEEK   = 8'd6;
    localparam logic [7:0] W_PIN    = 8'd7;
    localparam logic [7:0] W_DATA   = 8'd8;
    localparam logic [7:0] W_DMA    = 8'd9;
    localparam logic [7:0] W_WKEN   = 8'd10;
    localparam logic [7:0] W_WKFL   = 8'd11;

    // Control bits
    localparam int C_TXFLUSH = 5;
    localparam int C_RXFLUSH = 6;
    localparam int C_BCLK_EN = 15;
    localparam int C_BCLK_RDY = 19;
    localparam int C_THR_W = 4;

    // Status bits
    localparam int S_RXEMPTY = 4;
    localparam int S_TXEMPTY = 6;
    localparam int S_LEVEL_LSB = 8;

    // Flag bits
    localparam int F_RXTHR = 4;
    localparam int F_TXHE  = 6;

    // Reset value of pin control: request-to-send bit
    localparam logic [31:0] PIN_RESET = 32'h0000_0002;
endpackage

// File: rtl/uart_fe_rxfifo.sv
// Module: receive byte FIFO with concurrent push, pop and flush.
// Assumes: DEPTH is a power of two; callers never push when full
// nor pop when empty; flush takes priority over push and pop.
module uart_fe_rxfifo #(
    parameter int DEPTH = 8,
    parameter int WIDTH = 8,
    localparam int AW = $clog2(DEPTH),
    localparam int LW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    input  logic             flush,
    output logic [WIDTH-1:0] head,
    output logic [LW-1:0]    level,
    output logic             full,
    output logic             empty
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;

    // Store an accepted byte at the write pointer
    always_ff @(posedge clk) begin
        if (push && !flush) mem[wr_ptr] <= push_data;
    end

    // Advance pointers and occupancy; flush empties everything
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            if (push && !pop)      level <= level + 1'b1;
            else if (pop && !push) level <= level - 1'b1;
        end
    end

    // Oldest entry and occupancy status
    always_comb begin
        head  = mem[rd_ptr];
        full  = (level == LW'(DEPTH));
        empty = (level == '0);
    end
endmodule

// File: rtl/uart_fe_flags.sv
// Module: interrupt flag word with write-one-to-clear and event sets.
// Assumes: set events in the same cycle as a clear take priority.
module uart_fe_flags
    import uart_fe_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clr_we,
    input  logic [31:0] clr_mask,
    input  logic        set_rx,
    input  logic        set_tx,
    input  logic [31:0] enable,
    output logic [31:0] flags,
    output logic        irq
);
    logic [31:0] set_vec;

    // Collect this cycle's flag-setting events
    always_comb begin
        set_vec = '0;
        set_vec[F_RXTHR] = set_rx;
        set_vec[F_TXHE]  = set_tx;
    end

    // Clear written ones, then apply events
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (clr_we ? (flags & ~clr_mask) : flags) | set_vec;
    end

    // Interrupt request from stored flags and enables
    assign irq = |(flags & enable);
endmodule

// File: rtl/uart_reg_front.sv
// Module: register file and interrupt front end of a memory-mapped UART.
// Assumes: one access per cycle; read data is combinational in the access
// cycle and side effects (pop, writes) land at the closing edge; the
// transmit stream never stalls.
module uart_reg_front
    import uart_fe_pkg::*;
#(
    parameter int RX_DEPTH = 8,
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              rx_valid,
    input  logic [7:0]        rx_data,
    output logic              rx_ready,
    output logic              tx_valid,
    output logic [7:0]        tx_data,
    output logic              irq
);
    localparam int LVL_W = $clog2(RX_DEPTH + 1);
    localparam int WORD_W = ADDR_W - 2;

    logic [31:0] ctrl_q, inten_q, clkdiv_q, osr_q, pin_q, dma_q, wken_q, wkfl_q;
    logic [31:0] flag_q;
    logic [7:0]  fifo_head;
    logic [LVL_W-1:0] fifo_level;
    logic fifo_full, fifo_empty;
    logic aligned, wr_en, rd_en;
    logic [WORD_W-1:0] word;
    logic pop_req, push_req, flush_req, set_rx;
    logic [31:0] next_level;

    // Address decode: only aligned words are mapped
    always_comb begin
        aligned = (bus_addr[1:0] == 2'b00);
        word    = bus_addr[ADDR_W-1:2];
        wr_en   = bus_sel && bus_write && aligned;
        rd_en   = bus_sel && !bus_write && aligned;
    end

    // Stream handshake, FIFO control and threshold test
    always_comb begin
        flush_req  = wr_en && (word == WORD_W'(W_CTRL)) && bus_wdata[C_RXFLUSH];
        rx_ready   = ctrl_q[C_BCLK_EN] && !fifo_full && !flush_req;
        push_req   = rx_valid && rx_ready;
        pop_req    = rd_en && (word == WORD_W'(W_DATA)) && !fifo_empty;
        next_level = 32'(fifo_level) + 32'(push_req) - 32'(pop_req);
        set_rx     = push_req && (next_level >= 32'(ctrl_q[C_THR_W-1:0]));
    end

    uart_fe_rxfifo #(.DEPTH(RX_DEPTH), .WIDTH(8)) i_rxfifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push_req),
        .push_data (rx_data),
        .pop       (pop_req),
        .flush     (flush_req),
        .head      (fifo_head),
        .level     (fifo_level),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    uart_fe_flags i_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_we   (wr_en && (word == WORD_W'(W_FLAG))),
        .clr_mask (bus_wdata),
        .set_rx   (set_rx),
        .set_tx   (wr_en && (word == WORD_W'(W_DATA))),
        .enable   (inten_q),
        .flags    (flag_q),
        .irq      (irq)
    );

    // Writable registers and the transmit strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            inten_q  <= '0;
            clkdiv_q <= '0;
            osr_q    <= '0;
            pin_q    <= PIN_RESET;
            dma_q    <= '0;
            wken_q   <= '0;
            wkfl_q   <= '0;
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else begin
            tx_valid <= 1'b0;
            if (wr_en) begin
                case (word)
                    WORD_W'(W_CTRL): begin
                        ctrl_q <= bus_wdata;
                        ctrl_q[C_TXFLUSH] <= 1'b0;
                        ctrl_q[C_RXFLUSH] <= 1'b0;
                        if (bus_wdata[C_BCLK_EN]) ctrl_q[C_BCLK_RDY] <= 1'b1;
                    end
                    WORD_W'(W_INTEN):  inten_q  <= bus_wdata;
                    WORD_W'(W_CLKDIV): clkdiv_q <= bus_wdata;
                    WORD_W'(W_OSR):    osr_q    <= bus_wdata;
                    WORD_W'(W_PIN):    pin_q    <= bus_wdata;
                    WORD_W'(W_DMA):    dma_q    <= bus_wdata;
                    WORD_W'(W_WKEN):   wken_q   <= bus_wdata;
                    WORD_W'(W_WKFL):   wkfl_q   <= bus_wdata;
                    WORD_W'(W_DATA): begin
                        tx_valid <= 1'b1;
                        tx_data  <= bus_wdata[7:0];
                    end
                    default: ;
                endcase
            end
        end
    end

    // Read multiplexer; unmapped or misaligned reads give zero
    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            case (word)
                WORD_W'(W_CTRL): bus_rdata = ctrl_q;
                WORD_W'(W_STAT): begin
                    bus_rdata[S_LEVEL_LSB +: LVL_W] = fifo_level;
                    bus_rdata[S_TXEMPTY] = 1'b1;
                    bus_rdata[S_RXEMPTY] = fifo_empty;
                end
                WORD_W'(W_INTEN):  bus_rdata = inten_q;
                WORD_W'(W_FLAG):   bus_rdata = flag_q;
                WORD_W'(W_CLKDIV): bus_rdata = clkdiv_q;
                WORD_W'(W_OSR):    bus_rdata = osr_q;
                WORD_W'(W_PEEK):   bus_rdata = fifo_empty ? 32'd0 : {24'd0, fifo_head};
                WORD_W'(W_PIN):    bus_rdata = pin_q;
                WORD_W'(W_DATA):   bus_rdata = fifo_empty ? 32'd0 : {24'd0, fifo_head};
                WORD_W'(W_DMA):    bus_rdata = dma_q;
                WORD_W'(W_WKEN):   bus_rdata = wken_q;
                WORD_W'(W_WKFL):   bus_rdata = wkfl_q;
                default:           bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/uart_fe_checker.sv
// Module: temporal checks for the UART front end, bound to the top.
// Assumes: connected to the top's internal FIFO level and pop request.
module uart_fe_checker #(
    parameter int RX_DEPTH = 8,
    localparam int LVL_W = $clog2(RX_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_valid,
    input logic             rx_ready,
    input logic             pop,
    input logic [LVL_W-1:0] level,
    input logic [31:0]      ctrl,
    input logic [31:0]      flags,
    input logic             tx_valid,
    input logic             bus_sel,
    input logic             bus_write,
    input logic [9:0]       bus_addr,
    input logic [31:0]      bus_wdata
);
    logic push, flush_wr;
    logic [31:0] after_push;

    // Derived events seen at the ports
    always_comb begin
        push       = rx_valid && rx_ready;
        flush_wr   = bus_sel && bus_write && (bus_addr == 10'h000) && bus_wdata[6];
        after_push = 32'(level) + 32'd1 - 32'(pop);
    end

    // R1: no acceptance while full
    p_full_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (level == LVL_W'(RX_DEPTH)) |-> !rx_ready);

    // R1: no acceptance with baud clock disabled
    p_clock_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl[15] |-> !rx_ready);

    // R2: occupancy never exceeds depth
    p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(RX_DEPTH));

    // R3: push reaching threshold sets the flag
    p_threshold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !flush_wr && (after_push >= 32'(ctrl[3:0]))) |=> flags[4]);

    // R6: transmit strobe comes with the half-empty flag
    p_tx_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> flags[6]);

    // R7: flush empties the FIFO
    p_flush_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flush_wr |=> (level == '0));

    // R11: push with pop keeps occupancy
    p_push_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !flush_wr) |=> (level == $past(level)));
endmodule

bind uart_reg_front uart_fe_checker #(.RX_DEPTH(RX_DEPTH)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .pop       (pop_req),
    .level     (fifo_level),
    .ctrl      (ctrl_q),
    .flags     (flag_q),
    .tx_valid  (tx_valid),
    .bus_sel   (bus_sel),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata)
);

// File: tb/test_uart_reg_front.sv
// Bench: directed and swept checks of the UART front end, 50 MHz clock.
module test_uart_reg_front;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_sel = 1'b0, bus_write = 1'b0;
    logic [9:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic rx_ready, tx_valid, irq;
    logic [7:0] tx_data;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    uart_reg_front i_uart_reg_front (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        #1 bus_sel = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [9:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_write = 1'b0; bus_addr = a;
        #5 d = bus_rdata;
        @(posedge clk);
        #1 bus_sel = 1'b0;
    endtask

    task automatic rdchk(input string req, input logic [9:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, v, exp);
    endtask

    task automatic push(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b;
        @(posedge clk);
        #1 rx_valid = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R9: reset state
        check("R9 irq", {31'd0, irq}, 32'd0);
        check("R9 rx_ready", {31'd0, rx_ready}, 32'd0);
        rdchk("R9 status", 10'h004, 32'h50);
        rdchk("R9 pin", 10'h01C, 32'h2);
        rdchk("R9 ctrl", 10'h000, 32'h0);
        rdchk("R9 flags", 10'h00C, 32'h0);

        // R7: flush bits dropped, ready bit follows enable
        wr(10'h000, 32'h0000_8063);
        rdchk("R7 ctrl store", 10'h000, 32'h0008_8003);

        // R3/R4/R8: fill with threshold 3, RX-threshold interrupt enabled
        wr(10'h008, 32'h10);
        for (int n = 1; n <= 8; n++) begin
            push(8'(n * 17));
            rdchk("R8 level", 10'h004, (32'(n) << 8) | 32'h40);
            rdchk("R3 flag", 10'h00C, (n >= 3) ? 32'h10 : 32'h0);
            check("R4 irq", {31'd0, irq}, (n >= 3) ? 32'd1 : 32'd0);
        end
        check("R1 full", {31'd0, rx_ready}, 32'd0);
        push(8'h99);
        rdchk("R1 full drop", 10'h004, 32'h840);

        // R2: peek does not consume
        rdchk("R2 peek", 10'h018, 32'h11);
        rdchk("R2 peek again", 10'h018, 32'h11);
        rdchk("R2 pop", 10'h020, 32'h11);

        // R11: push and pop in one cycle
        @(negedge clk);
        rx_valid = 1'b1; rx_data = 8'hAB;
        bus_sel = 1'b1; bus_write = 1'b0; bus_addr = 10'h020;
        #5 check("R11 pop data", bus_rdata, 32'h22);
        @(posedge clk);
        #1 rx_valid = 1'b0; bus_sel = 1'b0;
        rdchk("R11 level kept", 10'h004, 32'h740);

        // R2: drain in order, then empty reads
        for (int n = 3; n <= 8; n++) rdchk("R2 order", 10'h020, 32'(n * 17));
        rdchk("R2 last", 10'h020, 32'hAB);
        rdchk("R2 empty pop", 10'h020, 32'h0);
        rdchk("R2 empty peek", 10'h018, 32'h0);
        rdchk("R8 empty", 10'h004, 32'h50);

        // R5: write-one-to-clear
        wr(10'h00C, 32'h40);
        rdchk("R5 keep", 10'h00C, 32'h10);
        wr(10'h00C, 32'h10);
        rdchk("R5 clear", 10'h00C, 32'h0);
        check("R4 irq low", {31'd0, irq}, 32'd0);

        // R6: transmit strobe and flag
        wr(10'h020, 32'h0000_01A5);
        #1 check("R6 tx_valid", {31'd0, tx_valid}, 32'd1);
        check("R6 tx_data", {24'd0, tx_data}, 32'hA5);
        @(posedge clk);
        #1 check("R6 one pulse", {31'd0, tx_valid}, 32'd0);
        rdchk("R6 flag", 10'h00C, 32'h40);
        check("R4 masked", {31'd0, irq}, 32'd0);
        wr(10'h008, 32'h40);
        #1 check("R4 enabled", {31'd0, irq}, 32'd1);
        wr(10'h00C, 32'hFFFF_FFFF);
        #1 check("R4 cleared", {31'd0, irq}, 32'd0);

        // R3: sweep every threshold 0..9 against occupancy 1..8
        for (int t = 0; t <= 9; t++) begin
            wr(10'h000, 32'h0000_8040 | 32'(t));
            wr(10'h00C, 32'hFFFF_FFFF);
            for (int n = 1; n <= 8; n++) begin
                push(8'(n));
                rdchk("R3 sweep", 10'h00C, (n >= t) ? 32'h10 : 32'h0);
            end
        end

        // R5: set in the same cycle as a clear wins
        wr(10'h000, 32'h0000_8040);
        wr(10'h00C, 32'hFFFF_FFFF);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = 8'h5A;
        bus_sel = 1'b1; bus_write = 1'b1; bus_addr = 10'h00C; bus_wdata = 32'h10;
        @(posedge clk);
        #1 rx_valid = 1'b0; bus_sel = 1'b0; bus_write = 1'b0;
        rdchk("R5 set wins", 10'h00C, 32'h10);

        // R7: flush empties
        push(8'h01); push(8'h02);
        rdchk("R7 before flush", 10'h004, 32'h340);
        wr(10'h000, 32'h0000_8040);
        rdchk("R7 flushed", 10'h004, 32'h50);

        // R1: baud clock off blocks reception
        wr(10'h000, 32'h0);
        check("R1 gated", {31'd0, rx_ready}, 32'd0);
        push(8'h77);
        rdchk("R1 gated drop", 10'h004, 32'h50);

        // R12: plain storage registers
        for (int i = 0; i < 6; i++) begin
            logic [9:0] a;
            case (i)
                0: a = 10'h010; 1: a = 10'h014; 2: a = 10'h01C;
                3: a = 10'h024; 4: a = 10'h028; default: a = 10'h02C;
            endcase
            wr(a, 32'hA500_0000 | (32'(i) << 4) | 32'h3);
            rdchk("R12 readback", a, 32'hA500_0000 | (32'(i) << 4) | 32'h3);
        end

        // R8/R10: ignored writes, unmapped and misaligned reads
        wr(10'h004, 32'hFFFF_FFFF);
        rdchk("R8 read-only", 10'h004, 32'h50);
        wr(10'h030, 32'hFFFF_FFFF);
        rdchk("R10 unmapped", 10'h030, 32'h0);
        rdchk("R10 top", 10'h3FC, 32'h0);
        wr(10'h011, 32'h1234);
        rdchk("R10 misaligned write", 10'h010, 32'hA500_0003);
        rdchk("R10 misaligned read", 10'h011, 32'h0);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule